// File: doc/BRIEF.md
# Interrupt Flag and Wake Controller

This block gathers three interrupt sources for a small 8-bit microcontroller core and turns them into an interrupt request and a wake-up signal. The sources are an external pin whose active edge is picked by a polarity input, a one-cycle overflow pulse from an 8-bit timer, and a change detector on a 4-bit slice of an I/O port. The change detector compares the synchronized port value against a snapshot that is reloaded each time the core reads the port.

Each source has a sticky flag and an enable in one 8-bit control/status register that the core reads and writes. Hardware only ever sets flags. Software clears them by writing 0. Wake-up needs only a flag together with its enable. Vectoring to the interrupt handler also needs the global enable. Hardware clears the global enable when the core takes an interrupt, and a return strobe sets it again.

Top module: `irq_wake_ctrl`

## Requirements
- R1: After reset, `csr_rdata` is 8'h00 and both `irq_req` and `wake` are 0.
- R2: With `edge_rise_sel`=1, a 0-to-1 change on `ext_pin` sets the pin flag (bit 1) on the third rising clock edge after the change, and not before. Falling changes have no effect in this mode.
- R3: With `edge_rise_sel`=0, a 1-to-0 change on `ext_pin` sets bit 1 on the third clock edge after the change. Rising changes have no effect in this mode.
- R4: A cycle with `tmr_ovf`=1 sets the timer flag (bit 2) on the next clock edge.
- R5: The port-change flag (bit 0) sets on the third edge after `port_hi` starts to differ from the snapshot. It keeps setting while the two differ. A `port_rd` pulse loads the synchronized port value into the snapshot.
- R6: Flags are never cleared by hardware. A write clears a flag only if no set event for that flag arrives in the same cycle, because a set event wins.
- R7: The register fields are: bit 7 global enable, bit 6 spare storage with no effect on the outputs, bit 5 timer enable, bit 4 pin enable, bit 3 port-change enable, and bits 2..0 the flags. A write loads all 8 bits.
- R8: `wake` is 1 exactly when some flag and its enable are both 1, whatever the global enable is.
- R9: `irq_req` is 1 exactly when `wake` is 1 and the global enable is 1.
- R10: `irq_taken` clears the global enable on the next edge. `irq_ret` sets it. `irq_taken` wins over `irq_ret`, and both win over a same-cycle write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| edge_rise_sel | input | 1 | 1 = rising edge active, 0 = falling edge active |
| port_hi | input | 4 | Asynchronous port bits watched for change |
| port_rd | input | 1 | Core read of the port; reloads the snapshot |
| tmr_ovf | input | 1 | Timer rollover pulse, one cycle |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read value |
| irq_taken | input | 1 | Core has vectored; clears the global enable |
| irq_ret | input | 1 | Return from interrupt; sets the global enable |
| irq_req | output | 1 | Interrupt request toward the core |
| wake | output | 1 | Wake-up request while the core sleeps |

## Verification
The whole state of the block can be read through `csr_rdata` on every cycle. A wrong flag, enable or global bit therefore shows up one edge after it goes wrong, and `wake` and `irq_req` follow within the same cycle. A fault in the synchronizer or the snapshot can only be seen as a flag that sets one edge early or late, or not at all. For that reason the pin and port sources are checked edge by edge around the third clock after a change, and again after a snapshot reload.

// File: rtl/irq_wake_pkg.sv
// Package: register field positions and source count shared by the
// interrupt controller modules and its checker.
package irq_wake_pkg;
    localparam int CSR_W   = 8;
    localparam int NSRC    = 3;   // port-change, pin, timer
    localparam int B_GIE   = 7;
    localparam int B_SPARE = 6;
    localparam int B_EN_LO = 3;   // enables occupy [5:3], paired with flags [2:0]
    localparam int B_FL_LO = 0;
    localparam int S_PORT  = 0;
    localparam int S_PIN   = 1;
    localparam int S_TMR   = 2;
endpackage

// File: rtl/bit_sync.sv
// Module: bit_sync
// A W-bit multi-flop synchronizer for asynchronous inputs.
// Assumes each bit may be sampled on its own, so no bus coherence is needed.
module bit_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // first stage samples the asynchronous input
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    genvar i;
    generate
        for (i = 1; i < STAGES; i++) begin : g_stage
            // later stages shift the sample along the chain
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= stg[i-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/src_detect.sv
// Module: src_detect
// Turns the synchronized pin into a one-cycle edge event of the chosen
// polarity, and reports when the synchronized port differs from a snapshot.
// Assumes its inputs are already synchronous to clk.
module src_detect #(
    parameter int PORT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_s,
    input  logic              rise_sel,
    input  logic [PORT_W-1:0] port_s,
    input  logic              snap_ld,
    output logic              pin_evt,
    output logic              port_evt
);
    logic              pin_d;
    logic [PORT_W-1:0] snap;

    // remember last pin level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) pin_d <= 1'b0;
        else        pin_d <= pin_s;
    end

    // reload the port snapshot when the core reads the port
    always_ff @(posedge clk) begin
        if (!rst_n)       snap <= '0;
        else if (snap_ld) snap <= port_s;
    end

    // edge of the selected polarity, and port mismatch
    always_comb begin
        pin_evt  = rise_sel ? (pin_s & ~pin_d) : (~pin_s & pin_d);
        port_evt = (port_s != snap);
    end
endmodule

// File: rtl/irq_csr.sv
// Module: irq_csr
// Holds the flags, enables, spare bit and global enable. Combines them
// into wake and interrupt request.
// Assumes set events are one-cycle or level and synchronous to clk.
module irq_csr
    import irq_wake_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  set_evt,
    input  logic             we,
    input  logic [CSR_W-1:0] wdata,
    input  logic             taken,
    input  logic             ret,
    output logic [CSR_W-1:0] rdata,
    output logic             wake,
    output logic             irq_req
);
    logic [NSRC-1:0] flags, flags_n, en, en_n;
    logic            gie, gie_n, spare, spare_n;

    // next state: write first, then hardware set events and gie strobes
    always_comb begin
        flags_n = we ? wdata[B_FL_LO +: NSRC] : flags;
        en_n    = we ? wdata[B_EN_LO +: NSRC] : en;
        spare_n = we ? wdata[B_SPARE] : spare;
        gie_n   = we ? wdata[B_GIE] : gie;
        flags_n = flags_n | set_evt;
        if (ret)   gie_n = 1'b1;
        if (taken) gie_n = 1'b0;
    end

    // register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
            en    <= '0;
            spare <= 1'b0;
            gie   <= 1'b0;
        end else begin
            flags <= flags_n;
            en    <= en_n;
            spare <= spare_n;
            gie   <= gie_n;
        end
    end

    // read view and request outputs
    always_comb begin
        rdata                    = '0;
        rdata[B_GIE]             = gie;
        rdata[B_SPARE]           = spare;
        rdata[B_EN_LO +: NSRC]   = en;
        rdata[B_FL_LO +: NSRC]   = flags;
        wake                     = |(flags & en);
        irq_req                  = wake & gie;
    end
endmodule

// File: rtl/irq_wake_ctrl.sv
// Module: irq_wake_ctrl (top)
// Interrupt flag and wake controller: synchronizes pin and port, detects
// events, latches flags and produces wake and interrupt request.
// Assumes tmr_ovf and all strobes are synchronous to clk.
module irq_wake_ctrl
    import irq_wake_pkg::*;
#(
    parameter int PORT_W    = 4,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_pin,
    input  logic              edge_rise_sel,
    input  logic [PORT_W-1:0] port_hi,
    input  logic              port_rd,
    input  logic              tmr_ovf,
    input  logic              csr_we,
    input  logic [CSR_W-1:0]  csr_wdata,
    output logic [CSR_W-1:0]  csr_rdata,
    input  logic              irq_taken,
    input  logic              irq_ret,
    output logic              irq_req,
    output logic              wake
);
    localparam int SYNC_W = PORT_W + 1;

    logic [SYNC_W-1:0] sync_q;
    logic              pin_evt, port_evt;
    logic [NSRC-1:0]   evts;

    bit_sync #(.W(SYNC_W), .STAGES(SYNC_STGS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({ext_pin, port_hi}),
        .q    (sync_q)
    );

    src_detect #(.PORT_W(PORT_W)) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_s   (sync_q[PORT_W]),
        .rise_sel(edge_rise_sel),
        .port_s  (sync_q[PORT_W-1:0]),
        .snap_ld (port_rd),
        .pin_evt (pin_evt),
        .port_evt(port_evt)
    );

    // gather the source events into flag order
    always_comb begin
        evts         = '0;
        evts[S_PORT] = port_evt;
        evts[S_PIN]  = pin_evt;
        evts[S_TMR]  = tmr_ovf;
    end

    irq_csr u_csr (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_evt(evts),
        .we     (csr_we),
        .wdata  (csr_wdata),
        .taken  (irq_taken),
        .ret    (irq_ret),
        .rdata  (csr_rdata),
        .wake   (wake),
        .irq_req(irq_req)
    );
endmodule

// File: rtl/irq_wake_chk.sv
// Module: irq_wake_chk
// Port-level properties of irq_wake_ctrl, attached with bind.
// Assumes the register layout in irq_wake_pkg.
module irq_wake_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tmr_ovf,
    input logic       csr_we,
    input logic [7:0] csr_rdata,
    input logic       irq_taken,
    input logic       irq_ret,
    input logic       irq_req,
    input logic       wake
);
    a_r6_port_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_we && csr_rdata[0]) |=> csr_rdata[0]);
    a_r6_pin_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_we && csr_rdata[1]) |=> csr_rdata[1]);
    a_r6_tmr_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_we && csr_rdata[2]) |=> csr_rdata[2]);
    a_r4_tmr_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> csr_rdata[2]);
    a_r9_req_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (csr_rdata[7] && wake));
    a_r10_taken_clears: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |=> !csr_rdata[7]);
    a_r10_ret_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !irq_taken) |=> csr_rdata[7]);
endmodule

bind irq_wake_ctrl irq_wake_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tmr_ovf  (tmr_ovf),
    .csr_we   (csr_we),
    .csr_rdata(csr_rdata),
    .irq_taken(irq_taken),
    .irq_ret  (irq_ret),
    .irq_req  (irq_req),
    .wake     (wake)
);

// File: tb/sim_irq_wake_ctrl.sv
// Bench: directed checks plus a behavioural reference model compared on
// every clock.
module sim_irq_wake_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_pin = 1'b0, edge_rise_sel = 1'b1, port_rd = 1'b0;
    logic [3:0] port_hi = 4'h0;
    logic       tmr_ovf = 1'b0, csr_we = 1'b0, irq_taken = 1'b0, irq_ret = 1'b0;
    logic [7:0] csr_wdata = 8'h00;
    logic [7:0] csr_rdata;
    logic       irq_req, wake;

    int total = 0, bad = 0, cycles = 0;
    bit done = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    irq_wake_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .edge_rise_sel(edge_rise_sel),
        .port_hi(port_hi), .port_rd(port_rd), .tmr_ovf(tmr_ovf), .csr_we(csr_we),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq_taken(irq_taken),
        .irq_ret(irq_ret), .irq_req(irq_req), .wake(wake)
    );

    // reference model: pin and port input histories plus register state
    bit pin_h[$];
    int port_h[$];
    bit m_pin_last;
    int m_snap;
    bit [2:0] m_fl, m_en;
    bit m_gie, m_spare;

    function automatic bit [7:0] m_rd();
        return {m_gie, m_spare, m_en, m_fl};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            pin_h = '{0, 0}; port_h = '{0, 0};
            m_pin_last = 0; m_snap = 0;
            m_fl = 0; m_en = 0; m_gie = 0; m_spare = 0;
        end else begin
            bit ps, ev_pin, ev_port;
            int qs;
            ps = pin_h[0];           // value that has crossed both stages
            qs = port_h[0];
            ev_pin  = edge_rise_sel ? (ps && !m_pin_last) : (!ps && m_pin_last);
            ev_port = (qs != m_snap);
            if (csr_we) begin
                m_gie = csr_wdata[7]; m_spare = csr_wdata[6];
                m_en = csr_wdata[5:3]; m_fl = csr_wdata[2:0];
            end
            m_fl = m_fl | {tmr_ovf, ev_pin, ev_port};
            if (irq_ret) m_gie = 1;
            if (irq_taken) m_gie = 0;
            if (port_rd) m_snap = qs;
            m_pin_last = ps;
            void'(pin_h.pop_front()); pin_h.push_back(ext_pin);
            void'(port_h.pop_front()); port_h.push_back(int'(port_hi));
        end
        #1;
        total++;
        if (csr_rdata !== m_rd() || wake !== |(m_fl & m_en) ||
            irq_req !== (|(m_fl & m_en) && m_gie)) begin
            bad++;
            $display("FAIL %s model: rdata=%h wake=%b req=%b expected rdata=%h wake=%b req=%b",
                     cur_req, csr_rdata, wake, irq_req, m_rd(), |(m_fl & m_en),
                     |(m_fl & m_en) && m_gie);
        end
    end

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        csr_we = 1; csr_wdata = v; tick(1); csr_we = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<=50000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        tick(3); rst_n = 1; tick(1);
        // R1 reset state: {req,wake,rdata}
        chk("R1", {irq_req, wake, csr_rdata}, 10'h000);
        cur_req = "R7";
        wr(8'hFF); chk("R7", {2'b00, csr_rdata}, 10'h0FF);
        wr(8'h40); chk("R7 spare no effect", {irq_req, wake, csr_rdata}, 10'h040);
        wr(8'h00); chk("R6 sw clear", {2'b00, csr_rdata}, 10'h000);
        // R2 rising edge, three-edge latency
        cur_req = "R2"; edge_rise_sel = 1; ext_pin = 1;
        tick(2); chk("R2 not early", {9'h0, csr_rdata[1]}, 10'h0);
        tick(1); chk("R2 set", {9'h0, csr_rdata[1]}, 10'h1);
        wr(8'h00); ext_pin = 0; tick(5);
        chk("R2 falling ignored", {2'b00, csr_rdata}, 10'h000);
        // R3 falling-edge mode
        cur_req = "R3"; edge_rise_sel = 0; ext_pin = 1; tick(5);
        chk("R3 rising ignored", {2'b00, csr_rdata}, 10'h000);
        ext_pin = 0; tick(2);
        chk("R3 not early", {9'h0, csr_rdata[1]}, 10'h0);
        tick(1); chk("R3 set", {9'h0, csr_rdata[1]}, 10'h1);
        wr(8'h00);
        // R4 timer overflow
        cur_req = "R4"; tmr_ovf = 1; tick(1); tmr_ovf = 0;
        chk("R4", {2'b00, csr_rdata}, 10'h004);
        wr(8'h00);
        // R5 port change against snapshot
        cur_req = "R5"; port_hi = 4'h5; tick(2);
        chk("R5 not early", {9'h0, csr_rdata[0]}, 10'h0);
        tick(1); chk("R5 set", {9'h0, csr_rdata[0]}, 10'h1);
        wr(8'h00); chk("R6 set beats clear", {9'h0, csr_rdata[0]}, 10'h1);
        port_rd = 1; tick(1); port_rd = 0;
        wr(8'h00); tick(3); chk("R5 snapshot reload", {2'b00, csr_rdata}, 10'h000);
        port_hi = 4'h1; tick(3); chk("R5 second change", {9'h0, csr_rdata[0]}, 10'h1);
        port_rd = 1; tick(1); port_rd = 0; wr(8'h00);
        // R8 wake without global enable
        cur_req = "R8"; wr(8'h20); tmr_ovf = 1; tick(1); tmr_ovf = 0;
        chk("R8 wake no gie", {irq_req, wake, csr_rdata}, {2'b01, 8'h24});
        wr(8'h04); chk("R8 no enable no wake", {irq_req, wake}, 10'h000);
        // R9 request needs global enable
        cur_req = "R9"; wr(8'hA4);
        chk("R9 req", {irq_req, wake, csr_rdata}, {2'b11, 8'hA4});
        // R10 global enable strobes
        cur_req = "R10"; irq_taken = 1; tick(1); irq_taken = 0;
        chk("R10 taken", {irq_req, wake, csr_rdata}, {2'b01, 8'h24});
        irq_ret = 1; tick(1); irq_ret = 0;
        chk("R10 ret", {irq_req, wake, csr_rdata}, {2'b11, 8'hA4});
        irq_taken = 1; irq_ret = 1; tick(1); irq_taken = 0; irq_ret = 0;
        chk("R10 taken wins", {9'h0, csr_rdata[7]}, 10'h0);
        irq_ret = 1; csr_we = 1; csr_wdata = 8'h24; tick(1);
        irq_ret = 0; csr_we = 0;
        chk("R10 ret beats write", {9'h0, csr_rdata[7]}, 10'h1);
        irq_taken = 1; csr_we = 1; csr_wdata = 8'hA4; tick(1);
        irq_taken = 0; csr_we = 0;
        chk("R10 taken beats write", {9'h0, csr_rdata[7]}, 10'h0);
        // random traffic against the model (R6 stickiness under mixed stimulus)
        cur_req = "R6";
        for (int i = 0; i < 3000; i++) begin
            ext_pin = 1'($urandom_range(0, 1));
            port_hi = 4'($urandom_range(0, 15));
            edge_rise_sel = ($urandom_range(0, 15) == 0) ? ~edge_rise_sel : edge_rise_sel;
            tmr_ovf = ($urandom_range(0, 7) == 0);
            port_rd = ($urandom_range(0, 3) == 0);
            csr_we = ($urandom_range(0, 9) == 0);
            csr_wdata = 8'($urandom);
            irq_taken = ($urandom_range(0, 11) == 0);
            irq_ret = ($urandom_range(0, 11) == 0);
            tick(1);
        end
        csr_we = 0; irq_taken = 0; irq_ret = 0; tmr_ovf = 0; port_rd = 0;
        tick(2);
        finish_run();
    end
endmodule